// File: doc/BRIEF.md
# Packed Halfword Dual-Multiply Unit

This block is the execute-stage datapath for a family of packed-SIMD multiply instructions. Each source operand is cut into 32-bit lanes, and each lane carries two signed 16-bit halves. For every lane, the unit forms one or two signed 16x16 products. It then returns one of three things: a single product, the sum of two products, or the difference of two products. The lane result is 32 bits wide. All lanes work in parallel under the same operation.

The unit takes the instruction's opcode, funct3 and funct7 fields along with both source operands. One clock edge later it presents the lane results, a result-valid pulse, a saturation pulse and an illegal-encoding pulse. The saturation pulse is meant to be ORed into a sticky status bit held outside the block. The result register keeps its value on cycles that do not carry an accepted operation.

Top module: `dmul_unit`

## Requirements
- R1: While reset is held, and in the first cycle after the synchronised release, `out_valid`, `out_illegal` and `out_sat` are 0 and `result` is all zeros.
- R2: Lane k occupies bits [32k+31:32k] of the operands and the result. The bottom half of a lane is its bits [15:0] and the top half is bits [31:16]. Lanes are computed independently and all use the same operation.
- R3: funct7 0000100 gives a.bottom*b.bottom, funct7 0001100 gives a.bottom*b.top, and funct7 0010100 gives a.top*b.top. Each is returned as a full 32-bit signed product.
- R4: funct7 0011100 gives a.bottom*b.bottom + a.top*b.top.
- R5: funct7 0011101 gives a.top*b.bottom + a.bottom*b.top.
- R6: For the two add forms (R4, R5), a lane saturates when all four of its halves equal 0x8000. That lane's result is 0x7FFFFFFF, and `out_sat` pulses together with `out_valid`. No other input sets `out_sat`.
- R7: funct7 0101100 gives a.top*b.top - a.bottom*b.bottom, funct7 0110100 gives a.bottom*b.bottom - a.top*b.top, and funct7 0111100 gives a.top*b.bottom - a.bottom*b.top. These forms never saturate and never raise `out_sat`.
- R8: An input is addressed to the unit when `in_valid`=1, funct3=001 and opcode=1110111. If an addressed input carries a funct7 outside the eight codes above, it pulses `out_illegal` and not `out_valid`. An input that is not addressed to the unit raises neither.
- R9: Results appear one clock after the input is sampled. `out_valid`, `out_illegal` and `out_sat` stay high for exactly one cycle per accepted input.
- R10: `result` changes only on a cycle where `out_valid` is 1. Otherwise it holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Instruction fields and operands are valid this cycle |
| funct7 | input | 7 | Operation select field |
| funct3 | input | 3 | Minor opcode field, must be 001 |
| opcode | input | 7 | Major opcode field, must be 1110111 |
| src_a | input | XLEN | First packed source operand |
| src_b | input | XLEN | Second packed source operand |
| out_valid | output | 1 | Result valid pulse |
| out_illegal | output | 1 | Unsupported funct7 pulse |
| out_sat | output | 1 | Saturation pulse for the sticky status bit |
| result | output | XLEN | Packed 32-bit lane results |

## Verification
Each operation is tried with small positive halves, mixed signs and lanes whose halves differ. With these patterns, a wrong bottom/top pick, swapped crossing or reversed subtraction order produces a visibly different value. The extreme halves 0x8000 and 0x7FFF are applied in every combination of lanes. The all-0x8000 lane separates the add forms, which clip and flag, from the subtract forms, which must pass that lane through untouched. A second lane left unsaturated at the same time shows that clipping stays within its own lane. Wrong opcode and funct3 values, unsupported funct7 codes and idle cycles separate accept, reject and hold behaviour, and a long run of random encodings and operands is compared every cycle against an integer model.

// File: rtl/dmul_pkg.sv
package dmul_pkg;

  localparam int HALF_W = 16;
  localparam int LANE_W = 32;

  localparam logic [6:0] OPC_PACKED = 7'b1110111;
  localparam logic [2:0] F3_HALFMUL = 3'b001;

  typedef enum logic [1:0] {
    CMB_ONE = 2'd0,
    CMB_ADD = 2'd1,
    CMB_SUB = 2'd2
  } cmb_e;

  // Operand routing for the two multipliers of a lane plus the combine mode.
  typedef struct packed {
    logic m0_a_top;
    logic m0_b_top;
    logic m1_a_top;
    logic m1_b_top;
    cmb_e cmb;
  } dm_ctl_t;

  localparam dm_ctl_t CTL_IDLE = '{1'b0, 1'b0, 1'b0, 1'b0, CMB_ONE};

endpackage

// File: rtl/dmul_decode.sv
module dmul_decode
  import dmul_pkg::*;
(
  input  logic       in_valid,
  input  logic [6:0] funct7,
  input  logic [2:0] funct3,
  input  logic [6:0] opcode,
  output logic       op_accept,
  output logic       op_illegal,
  output dm_ctl_t    ctl
);

  logic addressed;
  logic known;

  assign addressed = in_valid && (funct3 == F3_HALFMUL) && (opcode == OPC_PACKED);

  always_comb begin
    known = 1'b1;
    ctl   = CTL_IDLE;
    unique case (funct7)
      7'b0000100: ctl = '{1'b0, 1'b0, 1'b0, 1'b0, CMB_ONE};  // bottom x bottom
      7'b0001100: ctl = '{1'b0, 1'b1, 1'b0, 1'b0, CMB_ONE};  // bottom x top
      7'b0010100: ctl = '{1'b1, 1'b1, 1'b0, 1'b0, CMB_ONE};  // top x top
      7'b0011100: ctl = '{1'b0, 1'b0, 1'b1, 1'b1, CMB_ADD};  // straight pair sum
      7'b0011101: ctl = '{1'b1, 1'b0, 1'b0, 1'b1, CMB_ADD};  // crossed pair sum
      7'b0101100: ctl = '{1'b1, 1'b1, 1'b0, 1'b0, CMB_SUB};  // top minus bottom
      7'b0110100: ctl = '{1'b0, 1'b0, 1'b1, 1'b1, CMB_SUB};  // bottom minus top
      7'b0111100: ctl = '{1'b1, 1'b0, 1'b0, 1'b1, CMB_SUB};  // crossed difference
      default: begin
        known = 1'b0;
        ctl   = CTL_IDLE;
      end
    endcase
  end

  assign op_accept  = addressed && known;
  assign op_illegal = addressed && !known;

endmodule

// File: rtl/dmul_lane.sv
module dmul_lane
  import dmul_pkg::*;
(
  input  dm_ctl_t             ctl,
  input  logic [LANE_W-1:0]   a,
  input  logic [LANE_W-1:0]   b,
  output logic [LANE_W-1:0]   res,
  output logic                sat
);

  localparam int SUM_W = LANE_W + 1;
  localparam logic signed [SUM_W-1:0] POS_LIMIT = {2'b00, {(LANE_W-1){1'b1}}};

  logic signed [HALF_W-1:0] m0_a, m0_b, m1_a, m1_b;
  logic signed [LANE_W-1:0] prod0, prod1;
  logic signed [SUM_W-1:0]  ext0, ext1, comb;

  assign m0_a = ctl.m0_a_top ? a[LANE_W-1:HALF_W] : a[HALF_W-1:0];
  assign m0_b = ctl.m0_b_top ? b[LANE_W-1:HALF_W] : b[HALF_W-1:0];
  assign m1_a = ctl.m1_a_top ? a[LANE_W-1:HALF_W] : a[HALF_W-1:0];
  assign m1_b = ctl.m1_b_top ? b[LANE_W-1:HALF_W] : b[HALF_W-1:0];

  assign prod0 = m0_a * m0_b;
  assign prod1 = m1_a * m1_b;

  assign ext0 = {prod0[LANE_W-1], prod0};
  assign ext1 = {prod1[LANE_W-1], prod1};

  always_comb begin
    unique case (ctl.cmb)
      CMB_ADD: comb = ext0 + ext1;
      CMB_SUB: comb = ext0 - ext1;
      default: comb = ext0;
    endcase
  end

  // Only the sum of two most-negative squares can leave the 32-bit range.
  assign sat = (ctl.cmb == CMB_ADD) && (comb > POS_LIMIT);
  assign res = sat ? POS_LIMIT[LANE_W-1:0] : comb[LANE_W-1:0];

endmodule

// File: rtl/dmul_unit.sv
module dmul_unit
  import dmul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [6:0]      funct7,
  input  logic [2:0]      funct3,
  input  logic [6:0]      opcode,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            out_valid,
  output logic            out_illegal,
  output logic            out_sat,
  output logic [XLEN-1:0] result
);

  localparam int LANES = XLEN / LANE_W;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic    op_accept, op_illegal;
  dm_ctl_t ctl;

  dmul_decode u_decode (
    .in_valid   (in_valid),
    .funct7     (funct7),
    .funct3     (funct3),
    .opcode     (opcode),
    .op_accept  (op_accept),
    .op_illegal (op_illegal),
    .ctl        (ctl)
  );

  logic [XLEN-1:0]  lane_res;
  logic [LANES-1:0] lane_sat;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dmul_lane u_lane (
      .ctl (ctl),
      .a   (src_a[g*LANE_W +: LANE_W]),
      .b   (src_b[g*LANE_W +: LANE_W]),
      .res (lane_res[g*LANE_W +: LANE_W]),
      .sat (lane_sat[g])
    );
  end

  // Next-state logic.
  logic            res_en;
  logic [XLEN-1:0] res_d, res_q;
  logic            valid_d, valid_q, ill_d, ill_q, sat_d, sat_q;

  always_comb begin
    res_en  = op_accept;
    res_d   = res_en ? lane_res : res_q;
    valid_d = op_accept;
    ill_d   = op_illegal;
    sat_d   = op_accept && (|lane_sat);
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q   <= '0;
      valid_q <= 1'b0;
      ill_q   <= 1'b0;
      sat_q   <= 1'b0;
    end else begin
      res_q   <= res_d;
      valid_q <= valid_d;
      ill_q   <= ill_d;
      sat_q   <= sat_d;
    end
  end

  assign result      = res_q;
  assign out_valid   = valid_q;
  assign out_illegal = ill_q;
  assign out_sat     = sat_q;

endmodule

// File: rtl/dmul_unit_chk.sv
module dmul_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            in_valid,
  input logic [6:0]      funct7,
  input logic            out_valid,
  input logic            out_illegal,
  input logic            out_sat,
  input logic [XLEN-1:0] result
);

  AST_VALID_XOR_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({out_valid, out_illegal}));  // R8

  AST_SAT_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_sat |-> out_valid);  // R6

  AST_SAT_CLIPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_sat |-> (result[31:0] == 32'h7FFF_FFFF || result[XLEN-1 -: 32] == 32'h7FFF_FFFF));  // R6

  AST_SAT_ADD_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_sat |-> ($past(funct7) == 7'b0011100 || $past(funct7) == 7'b0011101));  // R7

  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid || out_illegal) |-> $past(in_valid));  // R9

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_valid |-> $stable(result));  // R10

endmodule

bind dmul_unit dmul_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .in_valid    (in_valid),
  .funct7      (funct7),
  .out_valid   (out_valid),
  .out_illegal (out_illegal),
  .out_sat     (out_sat),
  .result      (result)
);

// File: tb/dmul_unit_bench.sv
`timescale 1ns/1ps
module dmul_unit_bench;

  localparam int XLEN  = 64;
  localparam int LANES = XLEN / 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [6:0]      funct7;
  logic [2:0]      funct3;
  logic [6:0]      opcode;
  logic [XLEN-1:0] src_a, src_b;
  logic            out_valid, out_illegal, out_sat;
  logic [XLEN-1:0] result;

  always #4 clk = ~clk;  // 125 MHz

  dmul_unit #(.XLEN(XLEN)) u_dmul_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .funct7(funct7),
    .funct3(funct3), .opcode(opcode), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_sat(out_sat),
    .result(result)
  );

  typedef struct {
    bit              valid;
    bit              ill;
    bit              sat;
    logic [XLEN-1:0] res;
    string           tag;
  } exp_t;

  exp_t            expq[$];
  logic [XLEN-1:0] mdl_res;
  int              n_checks = 0;
  int              n_fail   = 0;
  bit              done     = 0;

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Integer reference for one lane; returns 0 in known when funct7 is unsupported.
  task automatic ref_lane(input logic [6:0] f7, input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] r, output bit s, output bit known, output string tag);
    longint al, ah, bl, bh, v;
    al = longint'(shortint'(a[15:0]));  ah = longint'(shortint'(a[31:16]));
    bl = longint'(shortint'(b[15:0]));  bh = longint'(shortint'(b[31:16]));
    known = 1; s = 0; v = 0; tag = "";
    case (f7)
      7'b0000100: begin v = al * bl;           tag = "R3 R2"; end
      7'b0001100: begin v = al * bh;           tag = "R3 R2"; end
      7'b0010100: begin v = ah * bh;           tag = "R3 R2"; end
      7'b0011100: begin v = al * bl + ah * bh; tag = "R4 R2"; end
      7'b0011101: begin v = ah * bl + al * bh; tag = "R5 R2"; end
      7'b0101100: begin v = ah * bh - al * bl; tag = "R7 R2"; end
      7'b0110100: begin v = al * bl - ah * bh; tag = "R7 R2"; end
      7'b0111100: begin v = ah * bl - al * bh; tag = "R7 R2"; end
      default:    known = 0;
    endcase
    if (v > 64'sd2147483647) begin v = 64'sd2147483647; s = 1; tag = "R6"; end
    r = v[31:0];
  endtask

  task automatic compare_pending();
    exp_t e;
    if (expq.size() == 0) return;
    e = expq.pop_front();
    check("R8 R9 valid", {{(XLEN-1){1'b0}}, out_valid}, {{(XLEN-1){1'b0}}, e.valid});
    check("R8 R9 illegal", {{(XLEN-1){1'b0}}, out_illegal}, {{(XLEN-1){1'b0}}, e.ill});
    check("R6 R7 sat", {{(XLEN-1){1'b0}}, out_sat}, {{(XLEN-1){1'b0}}, e.sat});
    check(e.tag, result, e.res);
  endtask

  task automatic step(input bit v, input logic [6:0] f7, input logic [2:0] f3,
                      input logic [6:0] opc, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    exp_t e;
    bit   hdr, known, s, anysat;
    logic [31:0] r;
    logic [XLEN-1:0] lanes;
    string t;
    @(negedge clk);
    compare_pending();
    hdr = v && (f3 == 3'b001) && (opc == 7'b1110111);
    anysat = 0; known = 0; t = "R10 hold";
    for (int k = 0; k < LANES; k++) begin
      ref_lane(f7, a[k*32 +: 32], b[k*32 +: 32], r, s, known, t);
      lanes[k*32 +: 32] = r;
      anysat |= s;
    end
    e.valid = hdr && known;
    e.ill   = hdr && !known;
    e.sat   = e.valid && anysat;
    if (e.valid) mdl_res = lanes;
    else t = "R10 hold";
    e.res = mdl_res;
    e.tag = t;
    expq.push_back(e);
    in_valid = v; funct7 = f7; funct3 = f3; opcode = opc; src_a = a; src_b = b;
  endtask

  task automatic op(input logic [6:0] f7, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    step(1'b1, f7, 3'b001, 7'b1110111, a, b);
  endtask

  task automatic idle();
    step(1'b0, 7'b0000100, 3'b001, 7'b1110111, {XLEN{1'b1}}, {XLEN{1'b1}});
  endtask

  localparam logic [6:0] OPS [8] = '{7'b0000100, 7'b0001100, 7'b0010100, 7'b0011100,
                                     7'b0011101, 7'b0101100, 7'b0110100, 7'b0111100};

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; funct7 = '0; funct3 = '0; opcode = '0; src_a = '0; src_b = '0;
    mdl_res = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1 valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1 result in reset", result, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid after release", {62'd0, out_valid, out_illegal}, 64'd0);
    check("R1 sat after release", {63'd0, out_sat}, 64'd0);
    check("R1 result after release", result, 64'd0);

    // Directed: distinct halves in each lane so pairing errors show (R2..R7)
    for (int i = 0; i < 8; i++) begin
      op(OPS[i], 64'h0003_0007_FFFB_0002, 64'h0005_FFF9_000B_0004);
      op(OPS[i], 64'h7FFF_8000_1234_FEDC, 64'h8000_7FFF_0F0F_F0F0);
      idle();  // R9 pulse drops, R10 hold
    end
    // R6: all-0x8000 lane 0 only, then both lanes; add forms clip, subtract forms do not (R7)
    for (int i = 0; i < 8; i++) begin
      op(OPS[i], 64'h0002_0003_8000_8000, 64'h0004_0005_8000_8000);
      op(OPS[i], 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
    end
    // R6: near miss, three halves 0x8000 and one 0x7FFF: no saturation
    op(7'b0011100, 64'h8000_7FFF_8000_7FFF, 64'h8000_8000_8000_8000);
    op(7'b0011101, 64'h7FFF_8000_7FFF_8000, 64'h8000_8000_8000_8000);
    // R8: unsupported funct7, wrong funct3, wrong opcode, valid low
    op(7'b0000000, 64'h1, 64'h1);
    op(7'b0011110, 64'h1, 64'h1);
    step(1'b1, 7'b0000100, 3'b000, 7'b1110111, 64'h0009_0009, 64'h0009_0009);
    step(1'b1, 7'b0000100, 3'b001, 7'b0110011, 64'h0009_0009, 64'h0009_0009);
    step(1'b0, 7'b0011110, 3'b001, 7'b1110111, 64'h0009_0009, 64'h0009_0009);
    // Back-to-back then idle gaps (R9, R10)
    op(7'b0000100, 64'h0000_0002_0000_0003, 64'h0000_0005_0000_0007);
    op(7'b0010100, 64'h0004_0000_0006_0000, 64'h0008_0000_000A_0000);
    idle(); idle();
    // Random mix of encodings and operands
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] f7;
      logic [63:0] a, b;
      int sel;
      sel = $urandom_range(0, 11);
      f7 = (sel < 8) ? OPS[sel] : 7'($urandom);
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) begin a[31:0] = 32'h8000_8000; b[31:0] = 32'h8000_8000; end
      if ($urandom_range(0, 9) == 0) idle();
      else if ($urandom_range(0, 15) == 0) step(1'b1, f7, 3'($urandom), 7'($urandom), a, b);
      else op(f7, a, b);
    end
    idle();
    idle();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule